// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This unit takes one IEEE-754 single-precision operand per cycle. It returns a single-precision value that holds a whole number. The rounding direction comes from a 2-bit mode field in a small control register. The result keeps floating-point format. Whenever the returned value differs from the operand, the unit raises a sticky inexact flag in the same register.

The control register has a write port that replaces only the mode field. It also has a read-back port that shows the mode and the sticky flag. An operand presented with `valid_i` is rounded using the mode held in the register during that cycle. Its result appears on the next cycle, qualified by `valid_o`.

Top module: `fp_rint_unit`

## Requirements
- R1: The mode field sits at `ctrl_o[1:0]` and uses the encoding 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. A write with `mode_we_i` replaces it with `mode_wdata_i` on the next clock edge. Without a write it holds its value. Reset sets it to 0.
- R2: In mode 0 the result is whichever of floor(x) and ceil(x) is closer to x. On an exact tie, the even one is chosen.
- R3: In mode 1, positive inputs give floor(x) and negative inputs give ceil(x).
- R4: In mode 2 the result is ceil(x).
- R5: In mode 3 the result is floor(x).
- R6: The sticky inexact flag is at `ctrl_o[2]`. It is cleared only by reset. It is set by any accepted operand whose result differs from the operand. A mode write leaves it unchanged.
- R7: NaNs, infinities and any operand with an unbiased exponent of 23 or more are returned bit for bit. They never set the inexact flag.
- R8: The sign of the operand is always kept. A negative value that rounds to zero yields -0.0 (0x80000000). Zeros of either sign are returned unchanged and are exact.
- R9: The result and `valid_o` appear exactly one cycle after `valid_i`. The rounding uses the mode stored in the register during the accepted cycle. A mode write in that same cycle does not affect the operand.
- R10: Magnitudes below 1.0, including subnormals, round to ±0.0 or ±1.0. Rounding up at any exponent carries into the exponent when the significand overflows (for example 1.5 to 2.0, or 3.5 to 4.0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand valid |
| op_i | input | 32 | Single-precision operand |
| mode_we_i | input | 1 | Write strobe for the mode field |
| mode_wdata_i | input | 2 | New mode value |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Rounded single-precision result |
| ctrl_o | output | 3 | Read-back: {inexact, mode[1:0]} |

## Verification
The bench targets exact ties in nearest mode at both an even and an odd integer. A design that rounds halves away from zero returns 3.0 for 2.5 and fails there. It drives values just below 2^23 whose fractional part is a single half-ulp. A wrong fraction mask at that exponent drops or keeps the wrong bit. It also checks rounding up across a power of two, where a design that forgets the exponent carry returns a value half as large. Small negative values must give -0.0, and subnormals in the upward mode must give 1.0. Finally, it checks that passthrough inputs leave the sticky flag clear and that a mode write in the same cycle as an operand does not affect that operand.

// File: rtl/fp_rint_pkg.sv
package fp_rint_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'd0,
    RM_ZERO  = 2'd1,
    RM_UP    = 2'd2,
    RM_DOWN  = 2'd3
  } rmode_e;

  typedef struct packed {
    logic              pass;
    logic              tiny;
    logic              sign;
    logic              lsb;
    logic              half;
    logic              rest;
    logic [WORD_W-1:0] trunc;
    logic [WORD_W-1:0] step;
  } rint_split_t;
endpackage

// File: rtl/fp_rint_split.sv
// Splits the operand into integral part, rounding step and fraction summary.
module fp_rint_split
  import fp_rint_pkg::*;
(
  input  logic [WORD_W-1:0] op_i,
  output rint_split_t       split_o
);
  localparam logic [EXP_W-1:0] INT_LIM = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] ONE_EXP = EXP_W'(BIAS);
  localparam logic [WORD_W-1:0] ONE_WORD = WORD_W'(BIAS) << MAN_W;

  logic [EXP_W-1:0]  exp_f;
  logic [MAN_W-1:0]  man_f;
  logic [EXP_W-1:0]  fsh;
  logic [WORD_W-1:0] step, fmask;

  assign exp_f = op_i[WORD_W-2 -: EXP_W];
  assign man_f = op_i[MAN_W-1:0];
  assign fsh   = INT_LIM - exp_f;
  assign step  = WORD_W'(1) << fsh;
  assign fmask = step - WORD_W'(1);

  always_comb begin
    split_o       = '0;
    split_o.sign  = op_i[WORD_W-1];
    split_o.pass  = (exp_f == '1) || (exp_f >= INT_LIM);
    split_o.tiny  = exp_f < ONE_EXP;
    if (split_o.pass) begin
      split_o.trunc = op_i;
    end else if (split_o.tiny) begin
      // |x| < 1: integral part is signed zero, step reaches 1.0
      split_o.trunc = {split_o.sign, {(WORD_W-1){1'b0}}};
      split_o.step  = ONE_WORD;
      split_o.half  = (exp_f == ONE_EXP - EXP_W'(1));
      split_o.rest  = split_o.half ? (man_f != '0) : (op_i[WORD_W-2:0] != '0);
    end else begin
      split_o.trunc = op_i & ~fmask;
      split_o.step  = step;
      split_o.half  = |(op_i & (step >> 1));
      split_o.rest  = |(op_i & (fmask >> 1));
      // at exponent 0 the integral part is 1, which is odd
      split_o.lsb   = (fsh == EXP_W'(MAN_W)) ? 1'b1 : |(op_i & step);
    end
  end
endmodule

// File: rtl/fp_rint_decide.sv
// Chooses between magnitude truncation and one integral step up.
module fp_rint_decide
  import fp_rint_pkg::*;
(
  input  logic [1:0]  mode_i,
  input  rint_split_t split_i,
  output logic        up_o,
  output logic        inexact_o
);
  logic frac_nz;
  assign frac_nz   = !split_i.pass && (split_i.half || split_i.rest);
  assign inexact_o = frac_nz;

  always_comb begin
    unique case (rmode_e'(mode_i))
      RM_NEAR: up_o = split_i.half && (split_i.rest || split_i.lsb);
      RM_ZERO: up_o = 1'b0;
      RM_UP:   up_o = frac_nz && !split_i.sign;
      RM_DOWN: up_o = frac_nz &&  split_i.sign;
      default: up_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_rint_ctrl.sv
module fp_rint_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [1:0] mode_wdata_i,
  input  logic       flag_set_i,
  output logic [1:0] mode_o,
  output logic       inexact_o
);
  logic [1:0] mode_q;
  logic       inexact_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 2'd0;
      inexact_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_wdata_i;
      if (flag_set_i) inexact_q <= 1'b1;
    end
  end

  assign mode_o    = mode_q;
  assign inexact_o = inexact_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_q)); // R1
  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> mode_q == $past(mode_wdata_i)); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inexact_q |=> inexact_q); // R6
endmodule

// File: rtl/fp_rint_unit.sv
module fp_rint_unit
  import fp_rint_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] op_i,
  input  logic        mode_we_i,
  input  logic [1:0]  mode_wdata_i,
  output logic        valid_o,
  output logic [31:0] result_o,
  output logic [2:0]  ctrl_o
);
  rint_split_t       split;
  logic              up, inexact;
  logic [1:0]        mode;
  logic              flag;
  logic [WORD_W-1:0] res_d, res_q;
  logic              vld_q;

  fp_rint_split u_split (.op_i(op_i), .split_o(split));

  fp_rint_decide u_decide (
    .mode_i(mode), .split_i(split), .up_o(up), .inexact_o(inexact)
  );

  fp_rint_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .flag_set_i(valid_i && inexact),
    .mode_o(mode), .inexact_o(flag)
  );

  // adding the step to the bit pattern carries into the exponent as needed
  assign res_d = up ? split.trunc + split.step : split.trunc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;
  assign ctrl_o   = {flag, mode};

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_IDLE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_PASS_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && split.pass |=> result_o == $past(op_i)); // R7
  AST_PASS_NOFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && split.pass && !flag |=> !ctrl_o[2]); // R7
  AST_SIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[31] == $past(op_i[31])); // R8
endmodule

// File: tb/fp_rint_unit_tb.sv
module fp_rint_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid_i = 0;
  logic [31:0] op_i = '0;
  logic        mode_we_i = 0;
  logic [1:0]  mode_wdata_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [2:0]  ctrl_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_rint_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .valid_o(valid_o), .result_o(result_o), .ctrl_o(ctrl_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; valid_i = 0; mode_we_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic set_mode(logic [1:0] m);
    mode_we_i = 1; mode_wdata_i = m;
    @(negedge clk);
    mode_we_i = 0;
    chk("R1", {30'd0, ctrl_o[1:0]}, {30'd0, m});
  endtask

  task automatic run(string req, logic [31:0] x, logic [31:0] exp);
    valid_i = 1; op_i = x;
    @(negedge clk);
    valid_i = 0;
    chk("R9", {31'd0, valid_o}, 32'd1);
    chk(req, result_o, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", {29'd0, ctrl_o}, 32'd0);
    chk("R9", {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_nearest();
    do_reset();
    set_mode(2'd0);
    run("R2", 32'h40200000, 32'h40000000);  // 2.5 -> 2
    run("R2", 32'h40600000, 32'h40800000);  // 3.5 -> 4, R10 carry
    run("R2", 32'h40300000, 32'h40400000);  // 2.75 -> 3
    run("R2", 32'h3F000000, 32'h00000000);  // 0.5 -> 0
    run("R2", 32'hC0200000, 32'hC0000000);  // -2.5 -> -2
    run("R2", 32'h4A800001, 32'h4A800000);  // 2^22+0.5 -> even
    run("R2", 32'h4A800003, 32'h4A800004);  // 2^22+1.5 -> even up
    run("R10", 32'h3F400000, 32'h3F800000); // 0.75 -> 1
    run("R8", 32'hBE800000, 32'h80000000);  // -0.25 -> -0
    run("R10", 32'h00000001, 32'h00000000); // subnormal
  endtask

  task automatic t_zero();
    do_reset();
    set_mode(2'd1);
    run("R3", 32'h40300000, 32'h40000000);
    run("R3", 32'hBFC00000, 32'hBF800000);
    run("R3", 32'h3F400000, 32'h00000000);
    run("R8", 32'hBE800000, 32'h80000000);
  endtask

  task automatic t_up();
    do_reset();
    set_mode(2'd2);
    run("R4", 32'h3FC00000, 32'h40000000);  // 1.5 -> 2, R10 carry
    run("R4", 32'hBFC00000, 32'hBF800000);
    run("R4", 32'h3E800000, 32'h3F800000);
    run("R8", 32'hBE800000, 32'h80000000);
    run("R4", 32'h3F800000, 32'h3F800000);
    run("R10", 32'h00000001, 32'h3F800000);
  endtask

  task automatic t_down();
    do_reset();
    set_mode(2'd3);
    run("R5", 32'h3FC00000, 32'h3F800000);
    run("R5", 32'hBFC00000, 32'hC0000000);
    run("R5", 32'hBE800000, 32'hBF800000);
    run("R5", 32'h3E800000, 32'h00000000);
    run("R8", 32'h80000000, 32'h80000000);
  endtask

  task automatic t_flags();
    do_reset();
    run("R6", 32'h40000000, 32'h40000000);
    chk("R6", {31'd0, ctrl_o[2]}, 32'd0);
    run("R7", 32'h4B000001, 32'h4B000001);
    run("R7", 32'h7F800000, 32'h7F800000);
    run("R7", 32'h7FC00001, 32'h7FC00001);
    run("R7", 32'hCB7FFFFF, 32'hCB7FFFFF);
    chk("R7", {31'd0, ctrl_o[2]}, 32'd0);
    run("R6", 32'h40200000, 32'h40000000);
    chk("R6", {31'd0, ctrl_o[2]}, 32'd1);
    set_mode(2'd2);
    chk("R6", {31'd0, ctrl_o[2]}, 32'd1);
    run("R6", 32'h3F800000, 32'h3F800000);
    chk("R6", {31'd0, ctrl_o[2]}, 32'd1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    valid_i = 1; op_i = 32'h3FC00000;
    mode_we_i = 1; mode_wdata_i = 2'd3;
    @(negedge clk);
    valid_i = 0; mode_we_i = 0;
    chk("R9", result_o, 32'h40000000);  // old mode nearest
    chk("R1", {30'd0, ctrl_o[1:0]}, 32'd3);
    run("R9", 32'h3FC00000, 32'h3F800000);
  endtask

  initial begin
    t_reset();
    t_nearest();
    t_zero();
    t_up();
    t_down();
    t_flags();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule